// File: doc/BRIEF.md
# Solar Converter Mode Sequencer

This block supervises a photovoltaic buck-boost converter. It decides, from sampled output voltage and current codes, a unity-ratio indication and a few configuration selects, which operating mode the converter is in. The modes are reset, soft-start, startup bypass, bypass (the panel drives the output directly) and tracking, where an external maximum-power search steers the duty cycle. The block drives a mode code, an enable that gates the PWM drivers, and a square wave used to keep the bypass switch on.

After release from reset the converter ramps for a fixed soft-start time. Output current then decides whether tracking starts at once or a startup bypass period runs first. From tracking the block drops into bypass when the converter has sat at unity ratio long enough, or at once when the force pin is pulled low. Bypass is left when output power drifts from the value captured at entry, and for a short tracking re-check at a fixed interval. All durations are counted in milliseconds from a prescaled tick, so they scale with the clock.

Top module: `pv_mode_seq`

## Requirements
- R1: `rst` (synchronous, active high) sets the mode to RESET. Driving `stop_n` low forces `pwm_en` and `sq_out` low in the same cycle, and the mode is RESET from the next clock edge. While in RESET with `stop_n` high, the mode becomes SOFT on the next edge. Mode codes: RESET=0, SOFT=1, STARTUP=2, BYPASS=3, TRACK=4.
- R2: SOFT lasts SOFT_MS milliseconds with `pwm_en` high.
- R3: At the end of SOFT the mode becomes TRACK if `iout >= i_hi` was seen at any time during SOFT. Otherwise it becomes STARTUP.
- R4: STARTUP lasts at least the time chosen by `start_sel`: 0 gives no time, 1 gives START_A_MS and 2 or 3 give START_B_MS. After that time it moves to TRACK once `iout >= i_hi`. Changes in output power have no effect while in STARTUP.
- R5: TRACK moves to STARTUP when `iout < i_lo`. With `i_lo <= iout < i_hi` the current mode is kept, whether it is TRACK or STARTUP.
- R6: In TRACK, `unity_i` held high without a break for the time chosen by `unity_sel` (0..3 select UNI0_MS..UNI3_MS) moves the mode to BYPASS. Any low cycle restarts that time.
- R7: In STARTUP and BYPASS, `pwm_en` is low and `sq_out` toggles every SQ_HALF clocks. In all other modes `sq_out` is low. `pwm_en` is high only in SOFT and TRACK.
- R8: On entry to BYPASS the product P = `vout*iout` is captured. BYPASS moves to TRACK when |P - P_entry| > P_entry>>5 with `pwr_sel`=0, or > P_entry>>6 with `pwr_sel`=1.
- R9: After RECHK_MS in BYPASS the mode moves to TRACK for a re-check. It returns to BYPASS after CHK_MS unless another exit applies first.
- R10: `force_n` passes through a two-flop synchroniser. When it is low, SOFT, STARTUP and TRACK move to BYPASS within three clocks. While it stays low, BYPASS is held: there is no re-check and no power exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_n | input | 1 | Active-low converter stop, returns to RESET |
| force_n | input | 1 | Active-low asynchronous force into bypass |
| unity_i | input | 1 | Converter is at 1:1 ratio |
| vout | input | W | Sampled output voltage code |
| iout | input | W | Sampled output current code |
| i_lo | input | W | Tracking exit current threshold |
| i_hi | input | W | Tracking start current threshold |
| start_sel | input | 2 | Startup bypass time select |
| unity_sel | input | 2 | Unity dwell time select |
| pwr_sel | input | 1 | Power exit fraction: 0 gives 1/32, 1 gives 1/64 |
| mode | output | 3 | Current mode code |
| pwm_en | output | 1 | PWM output gate enable |
| sq_out | output | 1 | Bypass switch drive square wave |

## Verification
The bench builds the block with 4 clocks per millisecond and a 3-clock half period. It shortens soft-start to 5 ms, the startup times to 20 and 40 ms, the unity dwells to 2..8 ms, the re-check interval to 30 ms and the re-check length to 6 ms. With these values every timed exit, the full re-check round trip and the longest startup period can each be measured against a cycle window within a few hundred clocks. The same build also covers both power fractions, the hysteresis band and holding the force pin across more than one re-check interval.

// File: rtl/pv_mode_pkg.sv
package pv_mode_pkg;
  typedef enum logic [2:0] {
    ST_RESET   = 3'd0,
    ST_SOFT    = 3'd1,
    ST_STARTUP = 3'd2,
    ST_BYPASS  = 3'd3,
    ST_TRACK   = 3'd4
  } mode_e;
endpackage

// File: rtl/pv_ms_tick.sv
module pv_ms_tick #(
  parameter int DIV = 100000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/pv_sq_gen.sv
module pv_sq_gen #(
  parameter int HALF = 125
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic sq
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
      sq  <= 1'b0;
    end else if (cnt == CW'(HALF - 1)) begin
      cnt <= '0;
      sq  <= ~sq;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pv_pwr_cmp.sv
module pv_pwr_cmp #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         capture,
  input  logic [W-1:0] v,
  input  logic [W-1:0] i,
  input  logic         fine_sel,
  output logic         exceed
);
  localparam int PW = 2 * W;
  logic [PW-1:0] prod, ref_q, diff, lim;

  assign prod = v * i;

  always_ff @(posedge clk) begin
    if (rst)          ref_q <= '0;
    else if (capture) ref_q <= prod;
  end

  always_comb begin
    diff   = (prod > ref_q) ? (prod - ref_q) : (ref_q - prod);
    lim    = fine_sel ? (ref_q >> 6) : (ref_q >> 5);
    exceed = diff > lim;
  end
endmodule

// File: rtl/pv_mode_seq.sv
module pv_mode_seq
  import pv_mode_pkg::*;
#(
  parameter int W          = 10,
  parameter int CLK_PER_MS = 100000,
  parameter int SQ_HALF    = 125,
  parameter int SOFT_MS    = 250,
  parameter int START_A_MS = 60000,
  parameter int START_B_MS = 120000,
  parameter int UNI0_MS    = 200,
  parameter int UNI1_MS    = 400,
  parameter int UNI2_MS    = 1000,
  parameter int UNI3_MS    = 2000,
  parameter int RECHK_MS   = 60000,
  parameter int CHK_MS     = 4000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         stop_n,
  input  logic         force_n,
  input  logic         unity_i,
  input  logic [W-1:0] vout,
  input  logic [W-1:0] iout,
  input  logic [W-1:0] i_lo,
  input  logic [W-1:0] i_hi,
  input  logic [1:0]   start_sel,
  input  logic [1:0]   unity_sel,
  input  logic         pwr_sel,
  output logic [2:0]   mode,
  output logic         pwm_en,
  output logic         sq_out
);
  localparam int M1   = (START_B_MS > START_A_MS) ? START_B_MS : START_A_MS;
  localparam int M2   = (RECHK_MS > M1) ? RECHK_MS : M1;
  localparam int M3   = (SOFT_MS > M2) ? SOFT_MS : M2;
  localparam int M4   = (CHK_MS > M3) ? CHK_MS : M3;
  localparam int TMAX = (UNI3_MS > M4) ? UNI3_MS : M4;
  localparam int TW   = $clog2(TMAX + 2);

  localparam logic [TW-1:0] L_SOFT  = TW'(SOFT_MS);
  localparam logic [TW-1:0] L_STA   = TW'(START_A_MS);
  localparam logic [TW-1:0] L_STB   = TW'(START_B_MS);
  localparam logic [TW-1:0] L_RECHK = TW'(RECHK_MS);
  localparam logic [TW-1:0] L_CHK   = TW'(CHK_MS);

  mode_e st, nst;
  logic [TW-1:0] tmr, utmr, start_lim, uni_lim;
  logic [1:0] fsync;
  logic tick, force_on, cur_hi, cur_lo, seen_hi, chk, chk_n;
  logic exceed, capture, pwm_q, sq_q, sq_en;

  pv_ms_tick #(.DIV(CLK_PER_MS)) u_tick (.clk(clk), .rst(rst), .tick(tick));

  pv_pwr_cmp #(.W(W)) u_pwr (
    .clk(clk), .rst(rst), .capture(capture), .v(vout), .i(iout),
    .fine_sel(pwr_sel), .exceed(exceed)
  );

  pv_sq_gen #(.HALF(SQ_HALF)) u_sq (.clk(clk), .rst(rst), .en(sq_en), .sq(sq_q));

  always_ff @(posedge clk) begin
    if (rst) fsync <= 2'b11;
    else     fsync <= {fsync[0], force_n};
  end

  assign force_on = !fsync[1];
  assign cur_hi   = iout >= i_hi;
  assign cur_lo   = iout < i_lo;

  always_comb begin
    case (start_sel)
      2'd0:    start_lim = '0;
      2'd1:    start_lim = L_STA;
      default: start_lim = L_STB;
    endcase
    case (unity_sel)
      2'd0:    uni_lim = TW'(UNI0_MS);
      2'd1:    uni_lim = TW'(UNI1_MS);
      2'd2:    uni_lim = TW'(UNI2_MS);
      default: uni_lim = TW'(UNI3_MS);
    endcase
  end

  always_comb begin
    nst   = st;
    chk_n = chk;
    if (!stop_n) begin
      nst = ST_RESET;
    end else begin
      case (st)
        ST_RESET: nst = ST_SOFT;
        ST_SOFT: begin
          if (force_on)             nst = ST_BYPASS;
          else if (tmr >= L_SOFT)   nst = (seen_hi || cur_hi) ? ST_TRACK : ST_STARTUP;
        end
        ST_STARTUP: begin
          if (force_on)                           nst = ST_BYPASS;
          else if (tmr >= start_lim && cur_hi)    nst = ST_TRACK;
        end
        ST_BYPASS: begin
          if (!force_on) begin
            if (exceed)                nst = ST_TRACK;
            else if (tmr >= L_RECHK) begin
              nst   = ST_TRACK;
              chk_n = 1'b1;
            end
          end
        end
        ST_TRACK: begin
          if (force_on)                    nst = ST_BYPASS;
          else if (cur_lo)                 nst = ST_STARTUP;
          else if (utmr >= uni_lim)        nst = ST_BYPASS;
          else if (chk && tmr >= L_CHK)    nst = ST_BYPASS;
        end
        default: nst = ST_RESET;
      endcase
    end
    if (nst != st && !(st == ST_BYPASS && nst == ST_TRACK && chk_n)) chk_n = 1'b0;
  end

  assign capture = (nst == ST_BYPASS) && (st != ST_BYPASS);
  assign sq_en   = (nst == ST_BYPASS) || (nst == ST_STARTUP);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_RESET;
      chk     <= 1'b0;
      tmr     <= '0;
      utmr    <= '0;
      seen_hi <= 1'b0;
      pwm_q   <= 1'b0;
    end else begin
      st    <= nst;
      chk   <= chk_n;
      pwm_q <= (nst == ST_SOFT) || (nst == ST_TRACK);
      if (nst != st)                 tmr <= '0;
      else if (tick && tmr != '1)    tmr <= tmr + 1'b1;
      if (st != ST_TRACK || nst != st || !unity_i) utmr <= '0;
      else if (tick && utmr != '1)                 utmr <= utmr + 1'b1;
      if (st != ST_SOFT)   seen_hi <= 1'b0;
      else if (cur_hi)     seen_hi <= 1'b1;
    end
  end

  assign mode   = st;
  assign pwm_en = pwm_q & stop_n;
  assign sq_out = sq_q & stop_n;
endmodule

// File: rtl/pv_mode_seq_chk.sv
module pv_mode_seq_chk #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst,
  input logic         stop_n,
  input logic [W-1:0] iout,
  input logic [W-1:0] i_lo,
  input logic [2:0]   mode,
  input logic         pwm_en,
  input logic         sq_out
);
  // R1
  stop_to_reset_chk: assert property (@(posedge clk) disable iff (rst)
    !stop_n |=> mode == 3'd0);

  // R1
  stop_gates_chk: assert property (@(posedge clk) disable iff (rst)
    !stop_n |-> (!pwm_en && !sq_out));

  // R1
  reset_to_soft_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd0 && stop_n) |=> mode == 3'd1);

  // R5
  hyst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd4 && iout >= i_lo && stop_n) |=> mode != 3'd2);

  // R7
  sq_mode_chk: assert property (@(posedge clk) disable iff (rst)
    sq_out |-> (mode == 3'd2 || mode == 3'd3));

  // R7
  pwm_mode_chk: assert property (@(posedge clk) disable iff (rst)
    pwm_en |-> (mode == 3'd1 || mode == 3'd4));

  // R8
  bypass_exit_chk: assert property (@(posedge clk) disable iff (rst)
    mode == 3'd3 |=> (mode == 3'd3 || mode == 3'd4 || mode == 3'd0));

  // R1
  mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
    mode <= 3'd4);
endmodule

bind pv_mode_seq pv_mode_seq_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .stop_n(stop_n), .iout(iout), .i_lo(i_lo),
  .mode(mode), .pwm_en(pwm_en), .sq_out(sq_out)
);

// File: tb/pv_mode_seq_bench.sv
module pv_mode_seq_bench;
  localparam int W = 10;
  logic clk = 1'b0;
  logic rst = 1'b1, stop_n = 1'b1, force_n = 1'b1, unity_i = 1'b0, pwr_sel = 1'b0;
  logic [W-1:0] vout = 10'd500, iout = 10'd50, i_lo = 10'd24, i_hi = 10'd40;
  logic [1:0] start_sel = 2'd1, unity_sel = 2'd1;
  logic [2:0] mode;
  logic pwm_en, sq_out;
  int vectors = 0, fails = 0;

  always #2.5 clk = ~clk;

  pv_mode_seq #(
    .W(W), .CLK_PER_MS(4), .SQ_HALF(3), .SOFT_MS(5), .START_A_MS(20),
    .START_B_MS(40), .UNI0_MS(2), .UNI1_MS(4), .UNI2_MS(6), .UNI3_MS(8),
    .RECHK_MS(30), .CHK_MS(6)
  ) u_pv_mode_seq (
    .clk(clk), .rst(rst), .stop_n(stop_n), .force_n(force_n), .unity_i(unity_i),
    .vout(vout), .iout(iout), .i_lo(i_lo), .i_hi(i_hi), .start_sel(start_sel),
    .unity_sel(unity_sel), .pwr_sel(pwr_sel), .mode(mode), .pwm_en(pwm_en),
    .sq_out(sq_out)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wait_mode(input logic [2:0] tgt, input int maxc, output int n);
    n = 0;
    while (mode !== tgt && n < maxc) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic sq_pattern(input string tag);
    int highs = 0, edges = 0;
    logic prev = sq_out;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (sq_out) highs++;
      if (sq_out != prev) edges++;
      prev = sq_out;
    end
    check(highs == 6 && edges >= 3, tag, highs, 6);
  endtask

  task automatic to_bypass();
    int n;
    unity_i = 1'b1;
    wait_mode(3'd3, 60, n);
    unity_i = 1'b0;
  endtask

  task automatic t_reset();
    cycles(3);
    check(mode == 3'd0, "R1 reset mode", mode, 0);
    check(!pwm_en && !sq_out, "R1 reset outputs", {pwm_en, sq_out}, 0);
  endtask

  task automatic t_soft_track();
    int n;
    rst = 1'b0;
    wait_mode(3'd1, 5, n);
    check(mode == 3'd1 && n <= 2, "R1 reset to soft", n, 1);
    cycles(2);
    check(pwm_en == 1'b1, "R2 soft pwm_en", pwm_en, 1);
    wait_mode(3'd4, 60, n);
    check(mode == 3'd4 && n >= 13 && n <= 22, "R2 R3 soft length to track", n, 19);
  endtask

  task automatic t_startup_a();
    int n;
    iout = 10'd20;
    wait_mode(3'd2, 5, n);
    check(mode == 3'd2 && n <= 2, "R5 track exit below i_lo", mode, 2);
    iout = 10'd50;
    vout = 10'd300;
    wait_mode(3'd4, 200, n);
    check(mode == 3'd4 && n >= 72 && n <= 86, "R4 startup sel1 length", n, 79);
    vout = 10'd500;
    iout = 10'd30;
    cycles(20);
    check(mode == 3'd4, "R5 track held inside band", mode, 4);
  endtask

  task automatic t_startup_zero();
    int n;
    start_sel = 2'd0;
    iout = 10'd20;
    wait_mode(3'd2, 5, n);
    iout = 10'd30;
    cycles(20);
    check(mode == 3'd2, "R5 startup held inside band", mode, 2);
    iout = 10'd40;
    wait_mode(3'd4, 5, n);
    check(mode == 3'd4 && n <= 2, "R4 zero startup time", n, 1);
  endtask

  task automatic t_unity();
    int n;
    iout = 10'd100;
    unity_i = 1'b1;
    cycles(8);
    unity_i = 1'b0;
    cycles(2);
    unity_i = 1'b1;
    cycles(8);
    check(mode == 3'd4, "R6 unity break restarts", mode, 4);
    wait_mode(3'd3, 40, n);
    check(mode == 3'd3 && n >= 4 && n <= 14, "R6 unity dwell to bypass", n, 9);
    unity_i = 1'b0;
    check(pwm_en == 1'b0, "R7 bypass pwm_en low", pwm_en, 0);
    sq_pattern("R7 bypass square wave");
  endtask

  task automatic t_power();
    int n;
    vout = 10'd510;
    cycles(10);
    check(mode == 3'd3, "R8 coarse small drift kept", mode, 3);
    vout = 10'd520;
    wait_mode(3'd4, 4, n);
    check(mode == 3'd4, "R8 coarse drift exits", mode, 4);
    check(sq_out == 1'b0, "R7 track square wave low", sq_out, 0);
    vout = 10'd500;
    pwr_sel = 1'b1;
    to_bypass();
    vout = 10'd505;
    cycles(10);
    check(mode == 3'd3, "R8 fine small drift kept", mode, 3);
    vout = 10'd510;
    wait_mode(3'd4, 4, n);
    check(mode == 3'd4, "R8 fine drift exits", mode, 4);
  endtask

  task automatic t_recheck();
    int n;
    vout = 10'd500;
    to_bypass();
    wait_mode(3'd4, 200, n);
    check(mode == 3'd4 && n >= 113 && n <= 124, "R9 recheck interval", n, 119);
    wait_mode(3'd3, 60, n);
    check(mode == 3'd3 && n >= 20 && n <= 27, "R9 recheck length", n, 24);
  endtask

  task automatic t_force();
    int n, bad = 0;
    wait_mode(3'd4, 200, n);
    force_n = 1'b0;
    wait_mode(3'd3, 6, n);
    check(mode == 3'd3 && n <= 3, "R10 force to bypass", n, 3);
    vout = 10'd700;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (mode != 3'd3) bad++;
    end
    check(bad == 0, "R10 force holds bypass", bad, 0);
    force_n = 1'b1;
    wait_mode(3'd4, 8, n);
    check(mode == 3'd4, "R10 release restores exits", mode, 4);
  endtask

  task automatic t_stop();
    int n;
    to_bypass();
    n = 0;
    while (!sq_out && n < 8) begin @(negedge clk); n++; end
    stop_n = 1'b0;
    #1;
    check(!sq_out && !pwm_en, "R1 stop gates outputs", {pwm_en, sq_out}, 0);
    @(negedge clk);
    check(mode == 3'd0, "R1 stop to reset", mode, 0);
    iout = 10'd10;
    start_sel = 2'd2;
    cycles(4);
    stop_n = 1'b1;
    wait_mode(3'd1, 3, n);
    wait_mode(3'd2, 40, n);
    check(mode == 3'd2, "R3 soft without current to startup", mode, 2);
    iout = 10'd50;
    wait_mode(3'd4, 250, n);
    check(mode == 3'd4 && n >= 150 && n <= 166, "R4 startup sel2 length", n, 159);
  endtask

  initial begin
    t_reset();
    t_soft_track();
    t_startup_a();
    t_startup_zero();
    t_unity();
    t_power();
    t_recheck();
    t_force();
    t_stop();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule